// File: doc/BRIEF.md
# AXI4 Write-Channel N-to-1 Merger

This block lets several AXI4 write masters share one AXI4 write slave. It handles only the write address, write data and write response channels. A round-robin arbiter grants the address channel to one master at a time. A master is only eligible when it presents a valid address and also raises a per-port flag saying its write data is ready to flow. Once an address has been accepted downstream, the data beats of that burst are taken from the same master. Bursts are served strictly in the order their addresses were granted, and each burst ends on the beat that carries WLAST.

To route write responses without a lookup table, the merger places the granting port's index above the master's own AWID bits on the slave side. It then decodes those upper bits of the returning BID. The response goes only to the owning master, and that master sees only its own ID width. With a single master the block becomes pure wiring and ignores the data-ready flag.

The block has no reset: every register starts from a declared initial value, as FPGA configuration provides. Lock, cache, protection, QoS, region, user and WID signals are not carried. Burst size and type are assumed to be constant.

Top module: `axi_write_merge`

## Requirements
- R1: A port can win the address channel only in a cycle in which both its AWVALID and its data-ready flag are high. While either is low, its address never appears on the slave side.
- R2: Arbitration is round-robin. The search for the next winner starts at the port just above the previous winner and wraps from the highest index to 0. Before any grant, port 0 is searched first.
- R3: While a grant is pending, the slave-side AWID is {port index, master AWID}, with the index in the top ceil(log2(NUM_PORTS)) bits. Address and length come from the granted port, and only that port's AWREADY follows the slave AWREADY.
- R4: In the cycle after a slave-side address handshake, the slave-side AWVALID is low. Addresses therefore issue at most every second cycle.
- R5: Write beats are taken from granted ports in grant order. Only the head port's WREADY follows the slave WREADY, combinationally, so one beat can pass every cycle. The head advances on the beat with WLAST high.
- R6: While no granted burst awaits data, the slave-side WVALID is low and every master WREADY is low, whatever the masters drive.
- R7: While ORDER_DEPTH granted bursts still await their WLAST beat, no new address grant is made. The grant resumes once a burst completes.
- R8: The top ceil(log2(NUM_PORTS)) bits of the slave BID select the port that sees BVALID, and the slave BREADY follows that port's BREADY. An index of NUM_PORTS or above reaches no port and gives BREADY low.
- R9: Every master's BID equals the low ID_W bits of the slave BID, and every master's BRESP equals the slave BRESP.
- R10: With NUM_PORTS = 1 all channels pass straight through with no added ID bits, and the data-ready flag has no effect.
- R11: With no reset, the block starts idle: with no requests, the slave-side AWVALID and WVALID and all master AWREADY and WREADY are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| leftAwValid | input | NUM_PORTS | Master AWVALID, one bit per port |
| leftAwReady | output | NUM_PORTS | Master AWREADY |
| leftAwId | input | NUM_PORTS*ID_W | Master AWID, port i at bits [i*ID_W +: ID_W] |
| leftAwAddr | input | NUM_PORTS*ADDR_W | Master AWADDR |
| leftAwLen | input | NUM_PORTS*LEN_W | Master AWLEN |
| leftDataAvail | input | NUM_PORTS | Per-port flag: write data for a burst is ready |
| leftWValid | input | NUM_PORTS | Master WVALID |
| leftWReady | output | NUM_PORTS | Master WREADY |
| leftWData | input | NUM_PORTS*DATA_W | Master WDATA |
| leftWStrb | input | NUM_PORTS*DATA_W/8 | Master WSTRB |
| leftWLast | input | NUM_PORTS | Master WLAST |
| leftBValid | output | NUM_PORTS | Master BVALID |
| leftBReady | input | NUM_PORTS | Master BREADY |
| leftBId | output | NUM_PORTS*ID_W | Master BID |
| leftBResp | output | NUM_PORTS*2 | Master BRESP |
| rightAwValid | output | 1 | Slave AWVALID |
| rightAwReady | input | 1 | Slave AWREADY |
| rightAwId | output | ID_W+ceil(log2(NUM_PORTS)) | Slave AWID with port index on top |
| rightAwAddr | output | ADDR_W | Slave AWADDR |
| rightAwLen | output | LEN_W | Slave AWLEN |
| rightWValid | output | 1 | Slave WVALID |
| rightWReady | input | 1 | Slave WREADY |
| rightWData | output | DATA_W | Slave WDATA |
| rightWStrb | output | DATA_W/8 | Slave WSTRB |
| rightWLast | output | 1 | Slave WLAST |
| rightBValid | input | 1 | Slave BVALID |
| rightBReady | output | 1 | Slave BREADY |
| rightBId | input | ID_W+ceil(log2(NUM_PORTS)) | Slave BID |
| rightBResp | input | 2 | Slave BRESP |

## Verification
A corrupted grant-order queue shows at the ports on the very next data cycle: the wrong master's WDATA appears on the slave side, or the wrong master sees WREADY. A miscounted fill level shows within a few cycles in two ways. A third master wins the address channel while two bursts are still outstanding, or the address channel stays silent after a burst completes. A wrong round-robin pointer or a wrong index insertion shows in the upper AWID bits of the next grant. Response misrouting shows in the same cycle as a BVALID on the wrong master or a BREADY taken from the wrong one.

// File: rtl/awm_pkg.sv
package awm_pkg;
  // Width of a port selector carried in the route strobes (up to 64 ports).
  localparam int unsigned SEL_W = 6;

  typedef logic [SEL_W-1:0] portSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     live;   // high from the first clock edge on
    logic     awOn;   // an address grant is pending
    portSel_t awIdx;  // port owning the pending grant
    logic     wOn;    // a granted burst awaits data
    portSel_t wIdx;   // port owning the oldest such burst
  } routeCtl_t;
endpackage

// File: rtl/awm_ctrl.sv
module awm_ctrl
  import awm_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned ORDER_DEPTH = 4
) (
  input  logic                 clk,
  input  logic [NUM_PORTS-1:0] leftAwValid,
  input  logic [NUM_PORTS-1:0] leftDataAvail,
  input  logic                 rightAwReady,
  input  logic                 wLastFire,
  output routeCtl_t            route
);
  localparam int unsigned PTR_W = (ORDER_DEPTH > 1) ? $clog2(ORDER_DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(ORDER_DEPTH + 1);

  logic             primed   = 1'b0;
  logic             grantOn  = 1'b0;
  portSel_t         grantIdx = '0;
  portSel_t         lastIdx  = portSel_t'(NUM_PORTS - 1);
  portSel_t         slots [ORDER_DEPTH] = '{default: '0};
  logic [PTR_W-1:0] wrPtr = '0;
  logic [PTR_W-1:0] rdPtr = '0;
  logic [CNT_W-1:0] fill  = '0;

  logic [NUM_PORTS-1:0] reqVec;
  logic [NUM_PORTS-1:0] validShift;
  logic                 anyReq;
  portSel_t             pick;
  logic                 awFire;
  logic                 popNow;
  logic                 queueFull;
  logic                 canGrant;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ORDER_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign reqVec = leftAwValid & leftDataAvail;

  // Round-robin search starting just above the previous winner.
  always_comb begin
    logic [NUM_PORTS-1:0] shifted;
    anyReq = 1'b0;
    pick   = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      int cand;
      cand    = (int'(lastIdx) + k) % NUM_PORTS;
      shifted = reqVec >> cand;
      if (!anyReq && shifted[0]) begin
        anyReq = 1'b1;
        pick   = portSel_t'(cand);
      end
    end
  end

  assign validShift = leftAwValid >> grantIdx;
  assign awFire     = grantOn && rightAwReady && validShift[0];
  assign queueFull  = (fill == CNT_W'(ORDER_DEPTH));
  assign popNow     = wLastFire && (fill != '0);
  assign canGrant   = !grantOn && !queueFull && anyReq;

  always_ff @(posedge clk) begin
    primed <= 1'b1;
    if (canGrant) begin
      grantOn  <= 1'b1;
      grantIdx <= pick;
      lastIdx  <= pick;
    end else if (awFire) begin
      grantOn <= 1'b0;
    end
    if (awFire) begin
      slots[wrPtr] <= grantIdx;
      wrPtr        <= bump(wrPtr);
    end
    if (popNow) rdPtr <= bump(rdPtr);
    case ({awFire, popNow})
      2'b10:   fill <= fill + CNT_W'(1);
      2'b01:   fill <= fill - CNT_W'(1);
      default: fill <= fill;
    endcase
  end

  always_comb begin
    route       = '0;
    route.live  = primed;
    route.awOn  = grantOn;
    route.awIdx = grantIdx;
    route.wOn   = (fill != '0);
    route.wIdx  = slots[rdPtr];
  end

  // A port lacking valid or data-ready cannot hold the grant next cycle.
  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_qual
    AST_GRANT_QUALIFIED: assert property (@(posedge clk) disable iff (!primed)
      (!grantOn && !reqVec[gi]) |=> !(grantOn && grantIdx == portSel_t'(gi))); // R1
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!primed)
    fill <= CNT_W'(ORDER_DEPTH)); // R7
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!primed)
    (queueFull && !grantOn) |=> !grantOn); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!primed)
    wLastFire |-> fill != '0); // R5
endmodule

// File: rtl/awm_dpath.sv
module awm_dpath
  import awm_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3,
  parameter int unsigned ID_W      = 4,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned LEN_W     = 8,
  localparam int unsigned EXT_W    = $clog2(NUM_PORTS),
  localparam int unsigned R_ID_W   = ID_W + EXT_W,
  localparam int unsigned STRB_W   = DATA_W / 8
) (
  input  logic                        clk,
  input  routeCtl_t                   route,
  input  logic [NUM_PORTS-1:0]        leftAwValid,
  output logic [NUM_PORTS-1:0]        leftAwReady,
  input  logic [NUM_PORTS*ID_W-1:0]   leftAwId,
  input  logic [NUM_PORTS*ADDR_W-1:0] leftAwAddr,
  input  logic [NUM_PORTS*LEN_W-1:0]  leftAwLen,
  input  logic [NUM_PORTS-1:0]        leftWValid,
  output logic [NUM_PORTS-1:0]        leftWReady,
  input  logic [NUM_PORTS*DATA_W-1:0] leftWData,
  input  logic [NUM_PORTS*STRB_W-1:0] leftWStrb,
  input  logic [NUM_PORTS-1:0]        leftWLast,
  output logic [NUM_PORTS-1:0]        leftBValid,
  input  logic [NUM_PORTS-1:0]        leftBReady,
  output logic [NUM_PORTS*ID_W-1:0]   leftBId,
  output logic [NUM_PORTS*2-1:0]      leftBResp,
  output logic                        rightAwValid,
  input  logic                        rightAwReady,
  output logic [R_ID_W-1:0]           rightAwId,
  output logic [ADDR_W-1:0]           rightAwAddr,
  output logic [LEN_W-1:0]            rightAwLen,
  output logic                        rightWValid,
  input  logic                        rightWReady,
  output logic [DATA_W-1:0]           rightWData,
  output logic [STRB_W-1:0]           rightWStrb,
  output logic                        rightWLast,
  input  logic                        rightBValid,
  output logic                        rightBReady,
  input  logic [R_ID_W-1:0]           rightBId,
  input  logic [1:0]                  rightBResp
);
  logic [EXT_W-1:0] bPort;
  assign bPort = rightBId[R_ID_W-1 -: EXT_W];

  // Address channel: forward the granted port, tag its ID with the index.
  always_comb begin
    rightAwValid = 1'b0;
    rightAwId    = '0;
    rightAwAddr  = '0;
    rightAwLen   = '0;
    leftAwReady  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (route.awOn && route.awIdx == portSel_t'(i)) begin
        rightAwValid   = leftAwValid[i];
        rightAwId      = {EXT_W'(i), leftAwId[i*ID_W +: ID_W]};
        rightAwAddr    = leftAwAddr[i*ADDR_W +: ADDR_W];
        rightAwLen     = leftAwLen[i*LEN_W +: LEN_W];
        leftAwReady[i] = rightAwReady;
      end
    end
  end

  // Data channel: oldest granted burst owns the path.
  always_comb begin
    rightWValid = 1'b0;
    rightWData  = '0;
    rightWStrb  = '0;
    rightWLast  = 1'b0;
    leftWReady  = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (route.wOn && route.wIdx == portSel_t'(i)) begin
        rightWValid   = leftWValid[i];
        rightWData    = leftWData[i*DATA_W +: DATA_W];
        rightWStrb    = leftWStrb[i*STRB_W +: STRB_W];
        rightWLast    = leftWLast[i];
        leftWReady[i] = rightWReady;
      end
    end
  end

  // Response channel: decode the index bits, strip them on return.
  always_comb begin
    rightBReady = 1'b0;
    leftBValid  = '0;
    leftBId     = '0;
    leftBResp   = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      leftBId[i*ID_W +: ID_W] = rightBId[ID_W-1:0];
      leftBResp[i*2 +: 2]     = rightBResp;
      if (bPort == EXT_W'(i)) begin
        leftBValid[i] = rightBValid;
        rightBReady   = leftBReady[i];
      end
    end
  end

  AST_AW_HOLD: assert property (@(posedge clk) disable iff (!route.live)
    (rightAwValid && !rightAwReady) |=> (rightAwValid && $stable(rightAwId))); // R3
  AST_AW_GAP: assert property (@(posedge clk) disable iff (!route.live)
    (rightAwValid && rightAwReady) |=> !rightAwValid); // R4
  AST_W_ONEHOT: assert property (@(posedge clk) disable iff (!route.live)
    $onehot0(leftWReady)); // R5
  AST_B_ONEHOT: assert property (@(posedge clk) disable iff (!route.live)
    $onehot0(leftBValid)); // R8
endmodule

// File: rtl/axi_write_merge.sv
module axi_write_merge
  import awm_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned ORDER_DEPTH = 4,
  localparam int unsigned EXT_W      = $clog2(NUM_PORTS),
  localparam int unsigned R_ID_W     = ID_W + EXT_W,
  localparam int unsigned STRB_W     = DATA_W / 8
) (
  input  logic                        clk,
  input  logic [NUM_PORTS-1:0]        leftAwValid,
  output logic [NUM_PORTS-1:0]        leftAwReady,
  input  logic [NUM_PORTS*ID_W-1:0]   leftAwId,
  input  logic [NUM_PORTS*ADDR_W-1:0] leftAwAddr,
  input  logic [NUM_PORTS*LEN_W-1:0]  leftAwLen,
  input  logic [NUM_PORTS-1:0]        leftDataAvail,
  input  logic [NUM_PORTS-1:0]        leftWValid,
  output logic [NUM_PORTS-1:0]        leftWReady,
  input  logic [NUM_PORTS*DATA_W-1:0] leftWData,
  input  logic [NUM_PORTS*STRB_W-1:0] leftWStrb,
  input  logic [NUM_PORTS-1:0]        leftWLast,
  output logic [NUM_PORTS-1:0]        leftBValid,
  input  logic [NUM_PORTS-1:0]        leftBReady,
  output logic [NUM_PORTS*ID_W-1:0]   leftBId,
  output logic [NUM_PORTS*2-1:0]      leftBResp,
  output logic                        rightAwValid,
  input  logic                        rightAwReady,
  output logic [R_ID_W-1:0]           rightAwId,
  output logic [ADDR_W-1:0]           rightAwAddr,
  output logic [LEN_W-1:0]            rightAwLen,
  output logic                        rightWValid,
  input  logic                        rightWReady,
  output logic [DATA_W-1:0]           rightWData,
  output logic [STRB_W-1:0]           rightWStrb,
  output logic                        rightWLast,
  input  logic                        rightBValid,
  output logic                        rightBReady,
  input  logic [R_ID_W-1:0]           rightBId,
  input  logic [1:0]                  rightBResp
);
  if (NUM_PORTS == 1) begin : g_pass
    logic unusedPass;
    assign unusedPass   = ^{leftDataAvail, clk};
    assign rightAwValid = leftAwValid[0];
    assign leftAwReady  = rightAwReady;
    assign rightAwId    = leftAwId;
    assign rightAwAddr  = leftAwAddr;
    assign rightAwLen   = leftAwLen;
    assign rightWValid  = leftWValid[0];
    assign leftWReady   = rightWReady;
    assign rightWData   = leftWData;
    assign rightWStrb   = leftWStrb;
    assign rightWLast   = leftWLast[0];
    assign leftBValid   = rightBValid;
    assign rightBReady  = leftBReady[0];
    assign leftBId      = rightBId;
    assign leftBResp    = rightBResp;
  end else begin : g_merge
    routeCtl_t route;
    logic      wLastFire;

    assign wLastFire = rightWValid && rightWReady && rightWLast;

    awm_ctrl #(
      .NUM_PORTS  (NUM_PORTS),
      .ORDER_DEPTH(ORDER_DEPTH)
    ) u_ctrl (
      .clk          (clk),
      .leftAwValid  (leftAwValid),
      .leftDataAvail(leftDataAvail),
      .rightAwReady (rightAwReady),
      .wLastFire    (wLastFire),
      .route        (route)
    );

    awm_dpath #(
      .NUM_PORTS(NUM_PORTS),
      .ID_W     (ID_W),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W)
    ) u_dpath (
      .clk         (clk),
      .route       (route),
      .leftAwValid (leftAwValid),
      .leftAwReady (leftAwReady),
      .leftAwId    (leftAwId),
      .leftAwAddr  (leftAwAddr),
      .leftAwLen   (leftAwLen),
      .leftWValid  (leftWValid),
      .leftWReady  (leftWReady),
      .leftWData   (leftWData),
      .leftWStrb   (leftWStrb),
      .leftWLast   (leftWLast),
      .leftBValid  (leftBValid),
      .leftBReady  (leftBReady),
      .leftBId     (leftBId),
      .leftBResp   (leftBResp),
      .rightAwValid(rightAwValid),
      .rightAwReady(rightAwReady),
      .rightAwId   (rightAwId),
      .rightAwAddr (rightAwAddr),
      .rightAwLen  (rightAwLen),
      .rightWValid (rightWValid),
      .rightWReady (rightWReady),
      .rightWData  (rightWData),
      .rightWStrb  (rightWStrb),
      .rightWLast  (rightWLast),
      .rightBValid (rightBValid),
      .rightBReady (rightBReady),
      .rightBId    (rightBId),
      .rightBResp  (rightBResp)
    );
  end
endmodule

// File: tb/tb_axi_write_merge.sv
module tb_axi_write_merge;
  localparam int unsigned N  = 3;
  localparam int unsigned IW = 4;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam int unsigned LW = 8;
  localparam int unsigned SW = DW / 8;
  localparam int unsigned RW = IW + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Multi-port instance
  logic [N-1:0]    awValid = '0, awReady, avail = '0;
  logic [N*IW-1:0] awId = '0;
  logic [N*AW-1:0] awAddr = '0;
  logic [N*LW-1:0] awLen = '0;
  logic [N-1:0]    wValid = '0, wReady, wLast = '0;
  logic [N*DW-1:0] wData = '0;
  logic [N*SW-1:0] wStrb = '1;
  logic [N-1:0]    bValid, bReady = '0;
  logic [N*IW-1:0] bId;
  logic [N*2-1:0]  bResp;
  logic            rAwValid, rAwReady = 1'b0;
  logic [RW-1:0]   rAwId;
  logic [AW-1:0]   rAwAddr;
  logic [LW-1:0]   rAwLen;
  logic            rWValid, rWReady = 1'b0, rWLast;
  logic [DW-1:0]   rWData;
  logic [SW-1:0]   rWStrb;
  logic            rBValid = 1'b0, rBReady;
  logic [RW-1:0]   rBId = '0;
  logic [1:0]      rBResp = '0;

  axi_write_merge #(.NUM_PORTS(N), .ID_W(IW), .ADDR_W(AW), .DATA_W(DW),
                    .LEN_W(LW), .ORDER_DEPTH(2)) dut (
    .clk(clk), .leftAwValid(awValid), .leftAwReady(awReady), .leftAwId(awId),
    .leftAwAddr(awAddr), .leftAwLen(awLen), .leftDataAvail(avail),
    .leftWValid(wValid), .leftWReady(wReady), .leftWData(wData),
    .leftWStrb(wStrb), .leftWLast(wLast), .leftBValid(bValid),
    .leftBReady(bReady), .leftBId(bId), .leftBResp(bResp),
    .rightAwValid(rAwValid), .rightAwReady(rAwReady), .rightAwId(rAwId),
    .rightAwAddr(rAwAddr), .rightAwLen(rAwLen), .rightWValid(rWValid),
    .rightWReady(rWReady), .rightWData(rWData), .rightWStrb(rWStrb),
    .rightWLast(rWLast), .rightBValid(rBValid), .rightBReady(rBReady),
    .rightBId(rBId), .rightBResp(rBResp));

  // Single-port instance
  logic          sAwValid = 1'b0, sAwReady, sAvail = 1'b0;
  logic [IW-1:0] sAwId = '0;
  logic [AW-1:0] sAwAddr = '0;
  logic [LW-1:0] sAwLen = '0;
  logic          sWValid = 1'b0, sWReady, sWLast = 1'b0;
  logic [DW-1:0] sWData = '0;
  logic [SW-1:0] sWStrb = '1;
  logic          sBValid, sBReady = 1'b0;
  logic [IW-1:0] sBId;
  logic [1:0]    sBResp;
  logic          sRAwValid, sRAwReady = 1'b0;
  logic [IW-1:0] sRAwId;
  logic [AW-1:0] sRAwAddr;
  logic [LW-1:0] sRAwLen;
  logic          sRWValid, sRWReady = 1'b0, sRWLast;
  logic [DW-1:0] sRWData;
  logic [SW-1:0] sRWStrb;
  logic          sRBValid = 1'b0, sRBReady;
  logic [IW-1:0] sRBId = '0;
  logic [1:0]    sRBResp = '0;

  axi_write_merge #(.NUM_PORTS(1), .ID_W(IW), .ADDR_W(AW), .DATA_W(DW),
                    .LEN_W(LW), .ORDER_DEPTH(2)) dutSingle (
    .clk(clk), .leftAwValid(sAwValid), .leftAwReady(sAwReady), .leftAwId(sAwId),
    .leftAwAddr(sAwAddr), .leftAwLen(sAwLen), .leftDataAvail(sAvail),
    .leftWValid(sWValid), .leftWReady(sWReady), .leftWData(sWData),
    .leftWStrb(sWStrb), .leftWLast(sWLast), .leftBValid(sBValid),
    .leftBReady(sBReady), .leftBId(sBId), .leftBResp(sBResp),
    .rightAwValid(sRAwValid), .rightAwReady(sRAwReady), .rightAwId(sRAwId),
    .rightAwAddr(sRAwAddr), .rightAwLen(sRAwLen), .rightWValid(sRWValid),
    .rightWReady(sRWReady), .rightWData(sRWData), .rightWStrb(sRWStrb),
    .rightWLast(sRWLast), .rightBValid(sRBValid), .rightBReady(sRBReady),
    .rightBId(sRBId), .rightBResp(sRBResp));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Response routing vectors: slave BID, BRESP, master BREADY -> BVALID, BREADY
  typedef struct packed {
    logic [5:0] bid;
    logic [1:0] resp;
    logic [2:0] lready;
    logic [2:0] expValid;
    logic       expReady;
  } bVec_t;

  localparam bVec_t B_TABLE [5] = '{
    '{6'h05, 2'd0, 3'b001, 3'b001, 1'b1},
    '{6'h1A, 2'd2, 3'b101, 3'b010, 1'b0},
    '{6'h2F, 2'd1, 3'b100, 3'b100, 1'b1},
    '{6'h33, 2'd3, 3'b111, 3'b000, 1'b0},
    '{6'h10, 2'd0, 3'b010, 3'b010, 1'b1}
  };

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, all requirements, actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R11: idle from configuration, no reset
    @(negedge clk); #1;
    check("R11 rightAwValid idle", 32'(rAwValid), 32'd0);
    check("R11 rightWValid idle", 32'(rWValid), 32'd0);
    check("R11 awReady idle", 32'(awReady), 32'd0);
    check("R11 wReady idle", 32'(wReady), 32'd0);

    // R8 / R9 table walk
    foreach (B_TABLE[v]) begin
      rBValid = 1'b1;
      rBId    = B_TABLE[v].bid;
      rBResp  = B_TABLE[v].resp;
      bReady  = B_TABLE[v].lready;
      #1;
      check($sformatf("R8 bValid vec%0d", v), 32'(bValid), 32'(B_TABLE[v].expValid));
      check($sformatf("R8 bReady vec%0d", v), 32'(rBReady), 32'(B_TABLE[v].expReady));
      for (int p = 0; p < N; p++) begin
        check($sformatf("R9 bId vec%0d port%0d", v, p), 32'(bId[p*IW +: IW]), 32'(B_TABLE[v].bid[3:0]));
        check($sformatf("R9 bResp vec%0d port%0d", v, p), 32'(bResp[p*2 +: 2]), 32'(B_TABLE[v].resp));
      end
    end
    rBValid = 1'b0;
    bReady  = '0;

    // R1: valid without data-ready is never granted
    @(negedge clk);
    awValid[1] = 1'b1; awId[1*IW +: IW] = 4'h9; awAddr[1*AW +: AW] = 16'h1111; awLen[1*LW +: LW] = 8'd1;
    repeat (3) @(negedge clk);
    #1 check("R1 no grant without data-ready", 32'(rAwValid), 32'd0);
    avail[1] = 1'b1;
    @(negedge clk); #1;
    check("R1 grant once qualified", 32'(rAwValid), 32'd1);
    check("R3 AWID index on top", 32'(rAwId), 32'h19);
    check("R3 AWADDR forwarded", 32'(rAwAddr), 32'h1111);
    check("R3 AWLEN forwarded", 32'(rAwLen), 32'd1);
    rAwReady = 1'b1; #1;
    check("R3 AWREADY to granted port only", 32'(awReady), 32'b010);
    @(negedge clk);
    awValid[1] = 1'b0; avail[1] = 1'b0; rAwReady = 1'b0; #1;
    check("R4 AWVALID low after handshake", 32'(rAwValid), 32'd0);

    // R5: two-beat burst from port 1, port 0 also driving W
    wValid = 3'b011; wData[0*DW +: DW] = 16'hA0A0; wData[1*DW +: DW] = 16'hB1B1; wLast = 3'b001; #1;
    check("R5 W data from granted port", 32'(rWData), 32'hB1B1);
    check("R5 WREADY stall", 32'(wReady), 32'd0);
    rWReady = 1'b1; #1;
    check("R5 WREADY to head only", 32'(wReady), 32'b010);
    check("R5 WSTRB forwarded", 32'(rWStrb), 32'h3);
    @(negedge clk);
    wData[1*DW +: DW] = 16'hB1B2; wLast[1] = 1'b1; #1;
    check("R5 second beat data", 32'(rWData), 32'hB1B2);
    check("R5 second beat last", 32'(rWLast), 32'd1);
    @(negedge clk);
    wValid[1] = 1'b0; #1;
    check("R6 no WVALID when nothing granted", 32'(rWValid), 32'd0);
    check("R6 no WREADY when nothing granted", 32'(wReady), 32'd0);
    wValid = '0; wLast = '0; rWReady = 1'b0;

    // R2: round robin after port 1 -> port 2, then port 0
    awValid[0] = 1'b1; awId[0*IW +: IW] = 4'h3; avail[0] = 1'b1;
    awValid[2] = 1'b1; awId[2*IW +: IW] = 4'h7; avail[2] = 1'b1;
    @(negedge clk); #1;
    check("R2 first winner port 2", 32'(rAwId), 32'h27);
    rAwReady = 1'b1;
    @(negedge clk);
    awValid[2] = 1'b0; avail[2] = 1'b0; rAwReady = 1'b0; #1;
    check("R4 gap with request pending", 32'(rAwValid), 32'd0);
    @(negedge clk); #1;
    check("R2 second winner port 0", 32'(rAwId), 32'h03);
    rAwReady = 1'b1;
    @(negedge clk);
    awValid[0] = 1'b0; avail[0] = 1'b0; rAwReady = 1'b0;

    // R7: two outstanding bursts fill the order queue
    awValid[1] = 1'b1; awId[1*IW +: IW] = 4'hE; avail[1] = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R7 no grant while queue full", 32'(rAwValid), 32'd0);

    // R5: bursts drain in grant order 2 then 0
    wValid = 3'b111; wLast = 3'b111;
    wData[0*DW +: DW] = 16'hA0A0; wData[1*DW +: DW] = 16'hB1B1; wData[2*DW +: DW] = 16'hC2C2;
    rWReady = 1'b1; #1;
    check("R5 order head port 2 data", 32'(rWData), 32'hC2C2);
    check("R5 order head port 2 ready", 32'(wReady), 32'b100);
    @(negedge clk);
    wValid[2] = 1'b0; #1;
    check("R5 order next port 0 data", 32'(rWData), 32'hA0A0);
    check("R5 order next port 0 ready", 32'(wReady), 32'b001);
    @(negedge clk);
    wValid[0] = 1'b0; #1;
    check("R7 grant resumes after drain", 32'(rAwValid), 32'd1);
    check("R7 resumed grant port 1", 32'(rAwId), 32'h1E);
    check("R6 queue empty, no WVALID", 32'(rWValid), 32'd0);
    rAwReady = 1'b1;
    @(negedge clk);
    awValid[1] = 1'b0; avail[1] = 1'b0; rAwReady = 1'b0; #1;
    check("R5 port 1 burst data", 32'(rWData), 32'hB1B1);
    @(negedge clk);
    wValid = '0; wLast = '0; rWReady = 1'b0;

    // R10: single port passthrough ignores data-ready
    sAwValid = 1'b1; sAvail = 1'b0; sAwId = 4'hC; sAwAddr = 16'h2222; #1;
    check("R10 AWVALID passes with data-ready low", 32'(sRAwValid), 32'd1);
    check("R10 AWID unchanged", 32'(sRAwId), 32'hC);
    sRAwReady = 1'b1; #1;
    check("R10 AWREADY passes", 32'(sAwReady), 32'd1);
    sWValid = 1'b1; sWData = 16'h5A5A; sRWReady = 1'b1; #1;
    check("R10 W data passes", 32'(sRWData), 32'h5A5A);
    sRBValid = 1'b1; sRBId = 4'h6; #1;
    check("R10 BVALID passes", 32'(sBValid), 32'd1);
    check("R10 BID passes", 32'(sBId), 32'h6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule